// File: doc/BRIEF.md
# Clock Bank Mode and Enable Controller

This controller sets the operating mode of a clock bank with five outputs and one reference output. A single select bit in the mode byte decides where the frequency multiplier code and the spread-spectrum request come from. They come either from the strap pins or from the configuration bytes. The spread width is always taken from the mode byte. The controller registers the selected mode in the input-clock domain. It also publishes the multiplier factor that the PLL should lock to.

The controller does not generate the bank frequency itself. It takes the PLL output and passes it to each bank output through a per-output gate. Each gate's enable comes from a configuration byte. The enable is resynchronised into the bank clock domain and only changes while that clock is low. The reference output is the input clock, gated the same way. A bank-wide pin enable is passed straight through as a high-impedance request, with no clock involved. When test mode is selected, the bank is fed from the input clock divided by four instead of from the PLL. A lock flag from the PLL is synchronised and latched into an active-low good indicator.

Top module: `clkbank_ctrl`

## Requirements
- R1: With mode byte bit 0 = 1, one input-clock edge after sampling, mult_code equals {pin_s1, pin_s0} and spread_on equals the inverse of pin_ssc_n (a low pin requests spread).
- R2: With mode byte bit 0 = 0, one input-clock edge after sampling, mult_code equals mode byte bits 4:3 and spread_on equals mode byte bit 6 (1 = spread on); the strap pins have no effect.
- R3: mult_factor equals mult_code + 1, so code values 0, 1, 2 and 3 mean 1x, 2x, 3x and 4x the input clock.
- R4: spread_half equals mode byte bit 5 whatever the select bit is. Its value 1 means a downward spread of 0.5 % and 0 means a downward spread of 1.0 %.
- R5: bank_hiz is the inverse of pin_oe with no clock in the path. pin_oe has no effect on ref_clk.
- R6: Bank byte bit i (i = 0..4) = 1 lets bank_clk[i] toggle, and 0 holds it low. Reference byte bit 0 does the same for ref_clk.
- R7: An enable change reaches its output within three source-clock cycles. Every high pulse on a gated output lasts a full half period of its source, so no runt pulse appears.
- R8: Mode byte bit 7 = 0 selects test mode, and test_active is then 1 one edge later. In test mode each enabled bank output runs at the input clock divided by 4, and ref_clk runs at the input clock.
- R9: good_n falls on the third input-clock edge after pll_locked rises. It stays low after the lock is lost, until reset.
- R10: While reset is asserted, mult_code = 0, spread_on = 0, spread_half = 0, test_active = 0, good_n = 1, and all gated outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xin | input | 1 | Input reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_pll | input | 1 | Bank-frequency clock from the PLL |
| pin_s0 | input | 1 | Strap for the multiplier code, low bit |
| pin_s1 | input | 1 | Strap for the multiplier code, high bit |
| pin_ssc_n | input | 1 | Strap that requests spread when low |
| pin_oe | input | 1 | Bank output enable pin (low = high impedance) |
| pll_locked | input | 1 | Lock flag from the PLL |
| cfg_mode | input | 8 | Mode byte: select, code, spread, width, test |
| cfg_ref | input | 8 | Reference byte: bit 0 enables ref_clk |
| cfg_bank | input | 8 | Bank byte: bits 4:0 enable bank_clk[4:0] |
| mult_code | output | 2 | Selected multiplier code |
| mult_factor | output | 3 | Multiplier factor, 1 to 4 |
| spread_on | output | 1 | Spread modulation request |
| spread_half | output | 1 | Spread width: 1 = 0.5 %, 0 = 1.0 % |
| test_active | output | 1 | Test mode is in force |
| bank_clk | output | 5 | Gated bank clocks |
| bank_hiz | output | 1 | Request to tri-state the bank pads |
| ref_clk | output | 1 | Gated reference clock |
| good_n | output | 1 | Latched active-low lock indicator |

## Verification
The assertions assume that the strap pins, the configuration bytes and the lock flag change only away from a rising input-clock edge, so that each edge samples one stable value. The stimulus meets this by changing these inputs one nanosecond after an edge. The lock assertion also assumes that the lock flag is held for at least two edges once it is raised, and the bench holds it for much longer. The pulse-width monitor in the bench is switched off while the bank source moves between the PLL clock and the divided clock. That switch is a static configuration change and is not covered by the glitch-free claim.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

  localparam int CODE_W = 2;
  localparam int FACT_W = 3;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              spread_on;
    logic              spread_half;
    logic              test_active;
  } mode_t;

  // Pick the multiplier code from straps or register field.
  function automatic logic [CODE_W-1:0] pick_code(
    input logic              hw_sel,
    input logic [CODE_W-1:0] pin_code,
    input logic [CODE_W-1:0] reg_code
  );
    return hw_sel ? pin_code : reg_code;
  endfunction

  // Straps request spread when low; register requests it when high.
  function automatic logic pick_spread(
    input logic hw_sel,
    input logic pin_ssc_n,
    input logic reg_spread
  );
    return hw_sel ? ~pin_ssc_n : reg_spread;
  endfunction

  // Code 0..3 means 1x..4x the input clock.
  function automatic logic [FACT_W-1:0] code_to_factor(input logic [CODE_W-1:0] code);
    return FACT_W'(code) + FACT_W'(1);
  endfunction

endpackage

// File: rtl/clkbank_mode_sel.sv
module clkbank_mode_sel
  import clkbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_sel,
  input  logic              test_n,
  input  logic [CODE_W-1:0] pin_code,
  input  logic              pin_ssc_n,
  input  logic [CODE_W-1:0] reg_code,
  input  logic              reg_spread,
  input  logic              reg_half,
  output mode_t             mode_q
);

  mode_t mode_d;

  always_comb begin
    mode_d.code        = pick_code(hw_sel, pin_code, reg_code);
    mode_d.spread_on   = pick_spread(hw_sel, pin_ssc_n, reg_spread);
    mode_d.spread_half = reg_half;
    mode_d.test_active = ~test_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

endmodule

// File: rtl/clkbank_div.sv
module clkbank_div #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic clk_div
);

  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  // Top counter bit gives a 50 % duty divided clock.
  assign clk_div = cnt_q[DIV_LOG2-1];

endmodule

// File: rtl/clkbank_gate.sv
module clkbank_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic en_req,
  output logic en_live,
  output logic clk_out
);

  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], en_req};
  end

  // Falling-edge stage: the enable moves only while the source is low.
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en_live <= 1'b0;
    else        en_live <= sync_q[SYNC_STAGES-1];
  end

  assign clk_out = clk_src & en_live;

endmodule

// File: rtl/clkbank_lock.sv
module clkbank_lock #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic locked,
  output logic lock_seen,
  output logic good_n
);

  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], locked};
  end

  assign lock_seen = sync_q[SYNC_STAGES-1];

  // Sticky: cleared only by reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         good_n <= 1'b1;
    else if (lock_seen) good_n <= 1'b0;
  end

endmodule

// File: rtl/clkbank_ctrl.sv
module clkbank_ctrl
  import clkbank_pkg::*;
#(
  parameter int NUM_BANK    = 5,
  parameter int CFG_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG2    = 2
) (
  input  logic                clk_xin,
  input  logic                rst_n,
  input  logic                clk_pll,
  input  logic                pin_s0,
  input  logic                pin_s1,
  input  logic                pin_ssc_n,
  input  logic                pin_oe,
  input  logic                pll_locked,
  input  logic [CFG_W-1:0]    cfg_mode,
  input  logic [CFG_W-1:0]    cfg_ref,
  input  logic [CFG_W-1:0]    cfg_bank,
  output logic [CODE_W-1:0]   mult_code,
  output logic [FACT_W-1:0]   mult_factor,
  output logic                spread_on,
  output logic                spread_half,
  output logic                test_active,
  output logic [NUM_BANK-1:0] bank_clk,
  output logic                bank_hiz,
  output logic                ref_clk,
  output logic                good_n
);

  // Field positions in the mode byte.
  localparam int SEL_BIT    = 0;
  localparam int CODE_LO    = 3;
  localparam int CODE_HI    = CODE_LO + CODE_W - 1;
  localparam int HALF_BIT   = 5;
  localparam int SPREAD_BIT = 6;
  localparam int TESTN_BIT  = 7;
  localparam int REF_BIT    = 0;

  mode_t mode_q;
  logic  div_clk;
  logic  bank_src;
  logic  lock_seen;
  logic  ref_en_live;
  logic [NUM_BANK-1:0] bank_en_live;
  logic  unused_cfg;

  assign unused_cfg = ^{cfg_ref[CFG_W-1:REF_BIT+1], cfg_mode[CODE_LO-1:SEL_BIT+1],
                        cfg_bank[CFG_W-1:NUM_BANK]};

  clkbank_mode_sel u_mode (
    .clk        (clk_xin),
    .rst_n      (rst_n),
    .hw_sel     (cfg_mode[SEL_BIT]),
    .test_n     (cfg_mode[TESTN_BIT]),
    .pin_code   ({pin_s1, pin_s0}),
    .pin_ssc_n  (pin_ssc_n),
    .reg_code   (cfg_mode[CODE_HI:CODE_LO]),
    .reg_spread (cfg_mode[SPREAD_BIT]),
    .reg_half   (cfg_mode[HALF_BIT]),
    .mode_q     (mode_q)
  );

  assign mult_code   = mode_q.code;
  assign mult_factor = code_to_factor(mode_q.code);
  assign spread_on   = mode_q.spread_on;
  assign spread_half = mode_q.spread_half;
  assign test_active = mode_q.test_active;

  clkbank_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk     (clk_xin),
    .rst_n   (rst_n),
    .clk_div (div_clk)
  );

  // Bank source: PLL output normally, divided input clock in test mode.
  assign bank_src = mode_q.test_active ? div_clk : clk_pll;

  for (genvar i = 0; i < NUM_BANK; i++) begin : g_bank
    clkbank_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_src (bank_src),
      .rst_n   (rst_n),
      .en_req  (cfg_bank[i]),
      .en_live (bank_en_live[i]),
      .clk_out (bank_clk[i])
    );
  end

  clkbank_gate #(.SYNC_STAGES(SYNC_STAGES)) u_ref_gate (
    .clk_src (clk_xin),
    .rst_n   (rst_n),
    .en_req  (cfg_ref[REF_BIT]),
    .en_live (ref_en_live),
    .clk_out (ref_clk)
  );

  // Board-test path: no clock, no synchroniser.
  assign bank_hiz = ~pin_oe;

  clkbank_lock #(.SYNC_STAGES(SYNC_STAGES)) u_lock (
    .clk       (clk_xin),
    .rst_n     (rst_n),
    .locked    (pll_locked),
    .lock_seen (lock_seen),
    .good_n    (good_n)
  );

endmodule

// File: rtl/clkbank_ctrl_chk.sv
module clkbank_ctrl_chk (
  input logic       clk_xin,
  input logic       rst_n,
  input logic       hw_sel,
  input logic       test_n,
  input logic [1:0] reg_code,
  input logic       reg_spread,
  input logic       reg_half,
  input logic       pin_s0,
  input logic       pin_s1,
  input logic       pin_ssc_n,
  input logic       pll_locked,
  input logic       lock_seen,
  input logic [1:0] mult_code,
  input logic [2:0] mult_factor,
  input logic       spread_on,
  input logic       spread_half,
  input logic       test_active,
  input logic       good_n
);

  a_r1_pin_code: assert property (@(posedge clk_xin) disable iff (!rst_n)
    hw_sel |=> (mult_code == $past({pin_s1, pin_s0})) && (spread_on == !$past(pin_ssc_n)));

  a_r2_reg_code: assert property (@(posedge clk_xin) disable iff (!rst_n)
    !hw_sel |=> (mult_code == $past(reg_code)) && (spread_on == $past(reg_spread)));

  a_r3_factor_range: assert property (@(posedge clk_xin) disable iff (!rst_n)
    (mult_factor != 3'd0) && (mult_factor <= 3'd4));

  a_r4_width: assert property (@(posedge clk_xin) disable iff (!rst_n)
    1'b1 |=> spread_half == $past(reg_half));

  a_r8_test_flag: assert property (@(posedge clk_xin) disable iff (!rst_n)
    1'b1 |=> test_active == !$past(test_n));

  a_r9_latched: assert property (@(posedge clk_xin) disable iff (!rst_n)
    !good_n |=> !good_n);

  a_r9_fall_cause: assert property (@(posedge clk_xin) disable iff (!rst_n)
    $fell(good_n) |-> $past(lock_seen));

endmodule

bind clkbank_ctrl clkbank_ctrl_chk u_chk (
  .clk_xin     (clk_xin),
  .rst_n       (rst_n),
  .hw_sel      (cfg_mode[0]),
  .test_n      (cfg_mode[7]),
  .reg_code    (cfg_mode[4:3]),
  .reg_spread  (cfg_mode[6]),
  .reg_half    (cfg_mode[5]),
  .pin_s0      (pin_s0),
  .pin_s1      (pin_s1),
  .pin_ssc_n   (pin_ssc_n),
  .pll_locked  (pll_locked),
  .lock_seen   (lock_seen),
  .mult_code   (mult_code),
  .mult_factor (mult_factor),
  .spread_on   (spread_on),
  .spread_half (spread_half),
  .test_active (test_active),
  .good_n      (good_n)
);

// File: tb/tb_clkbank_ctrl.sv
`timescale 1ns/1ps
module tb_clkbank_ctrl;

  localparam int NB = 5;

  logic clk_xin = 1'b0;
  logic clk_pll = 1'b0;
  logic rst_n = 1'b0;
  logic pin_s0 = 1'b0, pin_s1 = 1'b0, pin_ssc_n = 1'b1, pin_oe = 1'b1, pll_locked = 1'b0;
  logic [7:0] cfg_mode = 8'h81, cfg_ref = 8'h01, cfg_bank = 8'h1f;
  logic [1:0] mult_code;
  logic [2:0] mult_factor;
  logic spread_on, spread_half, test_active, bank_hiz, ref_clk, good_n;
  logic [NB-1:0] bank_clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  int cnt_bank [NB];
  int glitch [NB];
  int cnt_ref = 0;

  always #2 clk_xin = ~clk_xin;   // 250 MHz
  always #3 clk_pll = ~clk_pll;

  clkbank_ctrl dut (
    .clk_xin(clk_xin), .rst_n(rst_n), .clk_pll(clk_pll),
    .pin_s0(pin_s0), .pin_s1(pin_s1), .pin_ssc_n(pin_ssc_n), .pin_oe(pin_oe),
    .pll_locked(pll_locked), .cfg_mode(cfg_mode), .cfg_ref(cfg_ref), .cfg_bank(cfg_bank),
    .mult_code(mult_code), .mult_factor(mult_factor), .spread_on(spread_on),
    .spread_half(spread_half), .test_active(test_active), .bank_clk(bank_clk),
    .bank_hiz(bank_hiz), .ref_clk(ref_clk), .good_n(good_n)
  );

  initial for (int i = 0; i < NB; i++) begin cnt_bank[i] = 0; glitch[i] = 0; end

  for (genvar g = 0; g < NB; g++) begin : g_mon
    realtime t_rise = 0.0;
    always @(posedge bank_clk[g]) begin
      cnt_bank[g] = cnt_bank[g] + 1;
      t_rise = $realtime;
    end
    always @(negedge bank_clk[g])
      if (mon_on && ($realtime - t_rise) < 2.5) glitch[g] = glitch[g] + 1;
  end

  always @(posedge ref_clk) cnt_ref = cnt_ref + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk_xin);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4 - 100);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int snap [NB];
    int rsnap;

    // R10 reset state
    tick(4);
    chk(mult_code == 2'd0, "R10 code", mult_code, 0);
    chk(spread_on == 1'b0 && spread_half == 1'b0, "R10 spread", {spread_on, spread_half}, 0);
    chk(test_active == 1'b0, "R10 test", test_active, 0);
    chk(good_n == 1'b1, "R10 good_n", good_n, 1);
    chk(bank_clk == '0 && ref_clk == 1'b0, "R10 outputs", {bank_clk, ref_clk}, 0);
    @(negedge clk_xin);
    rst_n = 1'b1;
    tick(2);

    // R1 strap selection, swept, register fields held opposite
    for (int v = 0; v < 8; v++) begin
      {pin_s1, pin_s0, pin_ssc_n} = 3'(v);
      cfg_mode = {1'b1, ~pin_ssc_n ? 1'b0 : 1'b1, 1'b0, ~pin_s1, ~pin_s0, 2'b00, 1'b1};
      tick(2);
      chk(mult_code == {pin_s1, pin_s0}, "R1 code", mult_code, int'({pin_s1, pin_s0}));
      chk(spread_on == !pin_ssc_n, "R1 spread", spread_on, int'(!pin_ssc_n));
      chk(int'(mult_factor) == int'({pin_s1, pin_s0}) + 1, "R3 factor", mult_factor,
          int'({pin_s1, pin_s0}) + 1);
    end

    // R2 register selection, R4 width, straps held opposite
    for (int v = 0; v < 16; v++) begin
      logic [1:0] rc;
      logic rs, rh;
      rc = 2'(v);
      rs = v[2];
      rh = v[3];
      cfg_mode = {1'b1, rs, rh, rc, 2'b00, 1'b0};
      {pin_s1, pin_s0} = ~rc;
      pin_ssc_n = rs;
      tick(2);
      chk(mult_code == rc, "R2 code", mult_code, int'(rc));
      chk(spread_on == rs, "R2 spread", spread_on, int'(rs));
      chk(spread_half == rh, "R4 width", spread_half, int'(rh));
      chk(int'(mult_factor) == int'(rc) + 1, "R3 factor", mult_factor, int'(rc) + 1);
    end
    cfg_mode = 8'hA1;
    tick(2);
    chk(spread_half == 1'b1, "R4 width under straps", spread_half, 1);

    // R6 / R7 per-output enables, all patterns
    mon_on = 1'b1;
    for (int p = 0; p < 32; p++) begin
      cfg_bank = 8'(p);
      tick(10);
      for (int i = 0; i < NB; i++) snap[i] = cnt_bank[i];
      tick(10);
      for (int i = 0; i < NB; i++) begin
        int d;
        d = cnt_bank[i] - snap[i];
        if (p[i]) chk(d >= 5, "R6 enabled toggles", d, 6);
        else      chk(d == 0 && bank_clk[i] == 1'b0, "R6 disabled held low", d, 0);
      end
    end
    for (int i = 0; i < NB; i++) chk(glitch[i] == 0, "R7 no runt pulse", glitch[i], 0);
    cfg_bank = 8'h1f;

    // R6 reference enable
    cfg_ref = 8'h00;
    tick(6);
    rsnap = cnt_ref;
    tick(10);
    chk(cnt_ref == rsnap && ref_clk == 1'b0, "R6 ref disabled", cnt_ref - rsnap, 0);
    cfg_ref = 8'h01;
    tick(6);
    rsnap = cnt_ref;
    tick(10);
    chk(cnt_ref - rsnap == 10, "R6 ref enabled", cnt_ref - rsnap, 10);

    // R5 asynchronous bank enable pin
    @(posedge clk_xin);
    #0.5 pin_oe = 1'b0;
    #0.3;
    chk(bank_hiz == 1'b1, "R5 hiz without clock", bank_hiz, 1);
    rsnap = cnt_ref;
    tick(8);
    chk(cnt_ref - rsnap == 8, "R5 ref unaffected", cnt_ref - rsnap, 8);
    #0.5 pin_oe = 1'b1;
    #0.3;
    chk(bank_hiz == 1'b0, "R5 hiz released", bank_hiz, 0);

    // R8 test mode: bank = xin/4, ref = xin
    mon_on = 1'b0;
    cfg_mode = 8'h21;
    tick(2);
    chk(test_active == 1'b1, "R8 test flag", test_active, 1);
    tick(8);
    mon_on = 1'b1;
    for (int i = 0; i < NB; i++) snap[i] = cnt_bank[i];
    rsnap = cnt_ref;
    tick(64);
    for (int i = 0; i < NB; i++) begin
      int d;
      d = cnt_bank[i] - snap[i];
      chk(d >= 15 && d <= 17, "R8 bank at xin/4", d, 16);
    end
    chk(cnt_ref - rsnap == 64, "R8 ref at xin", cnt_ref - rsnap, 64);
    for (int i = 0; i < NB; i++) chk(glitch[i] == 0, "R7 no runt in test", glitch[i], 0);
    mon_on = 1'b0;
    cfg_mode = 8'hA1;
    tick(2);
    chk(test_active == 1'b0, "R8 test flag off", test_active, 0);

    // R9 lock indicator timing and latch
    chk(good_n == 1'b1, "R9 not locked yet", good_n, 1);
    @(posedge clk_xin);
    #1 pll_locked = 1'b1;
    tick(2);
    chk(good_n == 1'b1, "R9 still high after two edges", good_n, 1);
    tick(1);
    chk(good_n == 1'b0, "R9 low on third edge", good_n, 0);
    pll_locked = 1'b0;
    tick(10);
    chk(good_n == 1'b0, "R9 stays latched", good_n, 0);
    rst_n = 1'b0;
    #1;
    chk(good_n == 1'b1, "R10 reset clears good_n", good_n, 1);
    tick(2);
    rst_n = 1'b1;
    tick(4);
    chk(good_n == 1'b1, "R9 no lock after reset", good_n, 1);

    finish_run();
  end

endmodule